// File: doc/BRIEF.md
# T1 Transmit Payload Conditioner

This block sits on the bit-serial transmit path of a T1 link, ahead of the line coder. It takes one bit per enabled clock, together with a marker on the framing-bit slot of each 193-bit frame and a marker on the last frame of a twelve-frame D4 superframe. It conditions the 24 eight-bit channels before they go to the line. An all-zero channel can have its seventh bit forced to one to keep the ones density up. This can apply to every channel at once or to channels chosen by a mask. The block can also insert a D4 yellow alarm in either of two encodings and replace the whole stream with unframed all ones for a blue alarm. Framing bits are otherwise passed through untouched.

A channel is only known to be all zero after its eighth bit has arrived, so the stream goes through a one-channel delay before the output register. Alongside the data the block drives a channel clock that is high while the last bit of each channel is on the output. At 1.544 Mbit/s this gives 192 kHz. Generating framing bits, computing CRC, inserting signaling and line coding are handled elsewhere.

Top module: `t1_tx_conditioner`

## Requirements
- R1: With every conditioning function off, `data_o` after the k-th enabled clock equals the `data_i` sampled at the (k-8)-th enabled clock, framing slots included. Slot 0 of a frame is the framing bit, marked by `sof_i`. Slots 1..192 carry channels 1..24 in order, each sent bit 1 (MSB) first and bit 8 (LSB) last.
- R2: When a channel is stuffed, only its bit 7 changes, to one. Bit 8 and all other bits of the channel pass unchanged.
- R3: With `zs_en_i` and `stuff_all_i` high, every channel whose eight bits are all zero has bit 7 sent as one, whatever `stuff_mask_i` holds.
- R4: With `zs_en_i` high and `stuff_all_i` low, an all-zero channel n (1..24) is stuffed exactly when `stuff_mask_i[n-1]` is one.
- R5: With `zs_en_i` low, no channel is stuffed, whatever `stuff_all_i` and the mask hold.
- R6: With `yel_en_i` high and `yel_sbit_i` low, bit 2 of every channel is sent as zero, and framing bits are unchanged.
- R7: With `yel_en_i` and `yel_sbit_i` high, the framing bit of each frame whose `sof_i` slot had `mf_last_i` high is sent as one. All other slots are unchanged.
- R8: The bit-2 yellow encoding is applied before the all-zero test. A channel whose only one is bit 2 counts as all zero when that encoding is active.
- R9: With `blue_i` high, every output slot, framing bits included, is one. This takes precedence over yellow alarm and stuffing.
- R10: `chclk_o` is high exactly while `data_o` carries bit 8 of a channel. It is low on framing slots and on bits 1..7.
- R11: While reset is asserted, `data_o` and `chclk_o` are zero.
- R12: A clock with `bit_en_i` low changes neither `data_o` nor `chclk_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en_i | input | 1 | One T1 bit slot per high cycle |
| data_i | input | 1 | Serial payload bit |
| sof_i | input | 1 | High on the framing-bit slot |
| mf_last_i | input | 1 | With `sof_i`, marks the last frame of the superframe |
| zs_en_i | input | 1 | Enables bit-7 stuffing |
| stuff_all_i | input | 1 | Stuff every all-zero channel, ignoring the mask |
| stuff_mask_i | input | 24 | Per-channel stuffing select, bit n-1 for channel n |
| yel_en_i | input | 1 | Yellow alarm on |
| yel_sbit_i | input | 1 | Yellow encoding: 0 bit 2 zero, 1 framing bit of last frame one |
| blue_i | input | 1 | Unframed all-ones alarm |
| data_o | output | 1 | Conditioned serial bit |
| chclk_o | output | 1 | High during bit 8 of each channel |

## Verification
The main function is tried with several payload mixes. One mixes zero channels, channels holding only bit 2, channels holding only bit 8, and arbitrary bytes. The other is mostly zero with a few full channels. Running the same mix with stuffing off, global, and masked separates R3, R4 and R5, because a zero channel is stuffed in one run and left alone in another. The bit-2-only channels under the bit-2 yellow encoding show whether the alarm is applied before the zero test. The bit-8-only channels catch stuffing on the wrong bit position. A run with gaps in `bit_en_i` shows that the channel timing follows enabled slots, not clocks.

// File: rtl/t1pc_pkg.sv
package t1pc_pkg;
  // One slot as it travels through the channel delay
  typedef struct packed {
    logic dat;
    logic sof;
    logic mfl;
  } t1pc_slot_t;

  localparam int unsigned SLOT_W = $bits(t1pc_slot_t);
endpackage

// File: rtl/t1pc_pos_track.sv
// Tracks the slot position inside a frame; resync on the frame marker
module t1pc_pos_track #(
  parameter int unsigned CH_NUM  = 24,
  parameter int unsigned CH_BITS = 8,
  localparam int unsigned FRAME_BITS = CH_NUM * CH_BITS + 1,
  localparam int unsigned PW = $clog2(FRAME_BITS),
  localparam int unsigned BW = $clog2(CH_BITS),
  localparam int unsigned CW = $clog2(CH_NUM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          sof_i,
  output logic          fbit_o,
  output logic [CW-1:0] chan_o,
  output logic [BW-1:0] bit_o,
  output logic          last_o
);
  logic [PW-1:0] cnt_q, cnt_d, cur, pm1;

  always_comb begin
    if (sof_i)                              cur = '0;
    else if (cnt_q == PW'(FRAME_BITS - 1))  cur = '0;
    else                                    cur = cnt_q + PW'(1);
    pm1    = cur - PW'(1);
    fbit_o = (cur == '0);
    bit_o  = pm1[BW-1:0];
    chan_o = CW'(pm1 >> BW);
    last_o = !fbit_o && (bit_o == BW'(CH_BITS - 1));
    cnt_d  = en_i ? cur : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= PW'(FRAME_BITS - 1);
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/t1pc_zero_detect.sv
// Decides per channel whether bit 7 must be stuffed
module t1pc_zero_detect #(
  parameter int unsigned CH_NUM  = 24,
  parameter int unsigned CH_BITS = 8,
  localparam int unsigned BW = $clog2(CH_BITS),
  localparam int unsigned CW = $clog2(CH_NUM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              data_i,
  input  logic              fbit_i,
  input  logic [CW-1:0]     chan_i,
  input  logic [BW-1:0]     bit_i,
  input  logic              last_i,
  input  logic              zs_en_i,
  input  logic              stuff_all_i,
  input  logic [CH_NUM-1:0] mask_i,
  input  logic              yel_b2_i,
  output logic              stuff_o
);
  logic any_q, any_d, any_now, d_eff, sel;
  logic stuff_q, stuff_d;

  always_comb begin
    // bit 2 (index 1) counts as zero while the bit-2 yellow encoding runs
    d_eff   = data_i & ~(yel_b2_i && (bit_i == BW'(1)));
    any_now = (bit_i == '0) ? d_eff : (any_q | d_eff);
    sel     = stuff_all_i | ((32'(chan_i) < CH_NUM) ? mask_i[chan_i] : 1'b0);
    any_d   = any_q;
    stuff_d = stuff_q;
    if (en_i && !fbit_i) begin
      any_d = any_now;
      if (last_i) stuff_d = zs_en_i && sel && !any_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_q   <= 1'b0;
      stuff_q <= 1'b0;
    end else begin
      any_q   <= any_d;
      stuff_q <= stuff_d;
    end
  end

  assign stuff_o = stuff_q;

  // R5
  no_stuff_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && last_i && !zs_en_i) |=> !stuff_q);
endmodule

// File: rtl/t1pc_delay_line.sv
// One-channel slot delay so a whole channel is seen before bit 7 leaves
module t1pc_delay_line #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  logic [W-1:0] stg_q [DEPTH];
  logic [W-1:0] stg_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign stg_d[i] = en_i ? din_i : stg_q[i];
    end else begin : g_body
      assign stg_d[i] = en_i ? stg_q[i-1] : stg_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= '0;
      else        stg_q[i] <= stg_d[i];
    end
  end

  assign dout_o = stg_q[DEPTH-1];
endmodule

// File: rtl/t1pc_out_stage.sv
// Applies alarms and stuffing, registers the line bit and channel clock
module t1pc_out_stage #(
  parameter int unsigned CH_BITS = 8,
  localparam int unsigned BW = $clog2(CH_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          dat_i,
  input  logic          mfl_i,
  input  logic          fbit_i,
  input  logic [BW-1:0] bit_i,
  input  logic          stuff_i,
  input  logic          yel_en_i,
  input  logic          yel_sbit_i,
  input  logic          blue_i,
  output logic          data_o,
  output logic          chclk_o
);
  logic dat_nxt, clk_nxt, data_q, data_d, chclk_q, chclk_d;

  always_comb begin
    dat_nxt = dat_i;
    if (fbit_i) begin
      if (yel_en_i && yel_sbit_i && mfl_i) dat_nxt = 1'b1;
    end else begin
      if (yel_en_i && !yel_sbit_i && (bit_i == BW'(1))) dat_nxt = 1'b0;
      if (stuff_i && (bit_i == BW'(CH_BITS - 2)))       dat_nxt = 1'b1;
    end
    if (blue_i) dat_nxt = 1'b1;
    clk_nxt = !fbit_i && (bit_i == BW'(CH_BITS - 1));
    data_d  = en_i ? dat_nxt : data_q;
    chclk_d = en_i ? clk_nxt : chclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= 1'b0;
      chclk_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      chclk_q <= chclk_d;
    end
  end

  assign data_o  = data_q;
  assign chclk_o = chclk_q;

  // R9
  blue_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && blue_i) |=> data_o);
  // R6
  yel_bit2_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !blue_i && yel_en_i && !yel_sbit_i && !fbit_i && bit_i == BW'(1)) |=> !data_o);
  // R7
  yel_sbit_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && fbit_i && yel_en_i && yel_sbit_i && mfl_i) |=> data_o);
  // R10
  chclk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && chclk_o) |=> !chclk_o);
  // R12
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(data_o) && $stable(chclk_o)));
endmodule

// File: rtl/t1_tx_conditioner.sv
module t1_tx_conditioner
  import t1pc_pkg::*;
#(
  parameter int unsigned CH_NUM  = 24,
  parameter int unsigned CH_BITS = 8,
  localparam int unsigned BW = $clog2(CH_BITS),
  localparam int unsigned CW = $clog2(CH_NUM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en_i,
  input  logic              data_i,
  input  logic              sof_i,
  input  logic              mf_last_i,
  input  logic              zs_en_i,
  input  logic              stuff_all_i,
  input  logic [CH_NUM-1:0] stuff_mask_i,
  input  logic              yel_en_i,
  input  logic              yel_sbit_i,
  input  logic              blue_i,
  output logic              data_o,
  output logic              chclk_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic          i_fbit, i_last;
  logic [CW-1:0] i_chan;
  logic [BW-1:0] i_bit;
  logic          stuff;

  t1pc_pos_track #(.CH_NUM(CH_NUM), .CH_BITS(CH_BITS)) u_in_pos (
    .clk(clk), .rst_n(rst_n_int), .en_i(bit_en_i), .sof_i(sof_i),
    .fbit_o(i_fbit), .chan_o(i_chan), .bit_o(i_bit), .last_o(i_last));

  t1pc_zero_detect #(.CH_NUM(CH_NUM), .CH_BITS(CH_BITS)) u_zero (
    .clk(clk), .rst_n(rst_n_int), .en_i(bit_en_i), .data_i(data_i),
    .fbit_i(i_fbit), .chan_i(i_chan), .bit_i(i_bit), .last_i(i_last),
    .zs_en_i(zs_en_i), .stuff_all_i(stuff_all_i), .mask_i(stuff_mask_i),
    .yel_b2_i(yel_en_i && !yel_sbit_i), .stuff_o(stuff));

  t1pc_slot_t slot_in, slot_out;
  assign slot_in = '{dat: data_i, sof: sof_i, mfl: mf_last_i};

  t1pc_delay_line #(.DEPTH(CH_BITS), .W(SLOT_W)) u_dly (
    .clk(clk), .rst_n(rst_n_int), .en_i(bit_en_i),
    .din_i(slot_in), .dout_o(slot_out));

  logic          o_fbit, o_last_unused;
  logic [CW-1:0] o_chan_unused;
  logic [BW-1:0] o_bit;

  t1pc_pos_track #(.CH_NUM(CH_NUM), .CH_BITS(CH_BITS)) u_out_pos (
    .clk(clk), .rst_n(rst_n_int), .en_i(bit_en_i), .sof_i(slot_out.sof),
    .fbit_o(o_fbit), .chan_o(o_chan_unused), .bit_o(o_bit), .last_o(o_last_unused));

  t1pc_out_stage #(.CH_BITS(CH_BITS)) u_out (
    .clk(clk), .rst_n(rst_n_int), .en_i(bit_en_i),
    .dat_i(slot_out.dat), .mfl_i(slot_out.mfl), .fbit_i(o_fbit), .bit_i(o_bit),
    .stuff_i(stuff), .yel_en_i(yel_en_i), .yel_sbit_i(yel_sbit_i), .blue_i(blue_i),
    .data_o(data_o), .chclk_o(chclk_o));
endmodule

// File: tb/t1_tx_conditioner_bench.sv
module t1_tx_conditioner_bench;
  localparam int FB = 193;
  localparam int NB = 4 * FB;

  logic clk = 1'b0;
  logic rst_n, bit_en_i, data_i, sof_i, mf_last_i;
  logic zs_en_i, stuff_all_i, yel_en_i, yel_sbit_i, blue_i;
  logic [23:0] stuff_mask_i;
  logic data_o, chclk_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int cfg_sel;

  always #5 clk = ~clk;

  t1_tx_conditioner u_t1_tx_conditioner (
    .clk(clk), .rst_n(rst_n), .bit_en_i(bit_en_i), .data_i(data_i),
    .sof_i(sof_i), .mf_last_i(mf_last_i), .zs_en_i(zs_en_i),
    .stuff_all_i(stuff_all_i), .stuff_mask_i(stuff_mask_i),
    .yel_en_i(yel_en_i), .yel_sbit_i(yel_sbit_i), .blue_i(blue_i),
    .data_o(data_o), .chclk_o(chclk_o));

  function automatic logic [7:0] byte_of(int f, int ch);
    if (cfg_sel == 0) begin
      case (ch % 4)
        0: return 8'h00;
        1: return 8'h40;
        2: return 8'h01;
        default: return 8'(ch * 29 + f * 7 + 3);
      endcase
    end
    return (ch % 5 == 4) ? 8'hFF : 8'h00;
  endfunction

  function automatic logic in_bit(int idx);
    int f = idx / FB;
    int p = idx % FB;
    logic [7:0] b;
    if (p == 0) return (f == 2);
    b = byte_of(f, (p - 1) / 8);
    return b[7 - ((p - 1) % 8)];
  endfunction

  function automatic logic exp_bit(int idx);
    int f = idx / FB;
    int p = idx % FB;
    int ch;
    logic [7:0] b;
    if (blue_i) return 1'b1;
    if (p == 0) return (yel_en_i && yel_sbit_i && (f % 2 == 1)) ? 1'b1 : (f == 2);
    ch = (p - 1) / 8;
    b = byte_of(f, ch);
    if (yel_en_i && !yel_sbit_i) b[6] = 1'b0;
    if (zs_en_i && (stuff_all_i || stuff_mask_i[ch]) && b == 8'h00) b[1] = 1'b1;
    return b[7 - ((p - 1) % 8)];
  endfunction

  function automatic logic exp_clk(int idx);
    int p = idx % FB;
    return (p != 0) && ((p - 1) % 8 == 7);
  endfunction

  function automatic string tag_of(int idx);
    int p = idx % FB;
    int k = (p - 1) % 8 + 1;
    if (blue_i) return "R9";
    if (p == 0) return (yel_en_i && yel_sbit_i) ? "R7" : "R1";
    if (k == 2 && yel_en_i && !yel_sbit_i) return "R6";
    if (k == 7) begin
      if (!zs_en_i) return "R5";
      if (yel_en_i && !yel_sbit_i) return "R8";
      if (stuff_all_i) return "R3";
      return "R4";
    end
    if (k == 8 && zs_en_i) return "R2";
    return "R1";
  endfunction

  task automatic chk(input logic act, input logic expv, input string tag, input int idx);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s slot %0d: actual %b expected %b", tag, idx, act, expv);
    end
  endtask

  task automatic run_scn(input int sel, input logic zs, input logic all,
                         input logic [23:0] mask, input logic yel, input logic sb,
                         input logic blu, input logic gaps);
    int e = 0;
    int pe = -1;
    logic pen = 1'b0;
    logic ld = 1'b0;
    logic lc = 1'b0;
    cfg_sel = sel;
    zs_en_i = zs; stuff_all_i = all; stuff_mask_i = mask;
    yel_en_i = yel; yel_sbit_i = sb; blue_i = blu;
    bit_en_i = 0; data_i = 0; sof_i = 0; mf_last_i = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R11: outputs cleared in reset
    chk(data_o, 1'b0, "R11", -1);
    chk(chclk_o, 1'b0, "R11", -1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    for (int step = 0; step < 4000; step++) begin
      @(negedge clk);
      if (pen && pe >= 8) begin
        chk(data_o, exp_bit(pe - 8), tag_of(pe - 8), pe - 8);
        chk(chclk_o, exp_clk(pe - 8), "R10", pe - 8);
      end else if (!pen && step > 0) begin
        // R12: idle clock holds outputs
        chk(data_o, ld, "R12", pe);
        chk(chclk_o, lc, "R12", pe);
      end
      ld = data_o;
      lc = chclk_o;
      if (e >= NB) break;
      if (gaps && (step % 5 == 3)) begin
        bit_en_i = 0;
        pen = 1'b0;
      end else begin
        bit_en_i = 1;
        data_i = in_bit(e);
        sof_i = (e % FB == 0);
        mf_last_i = (e % FB == 0) && ((e / FB) % 2 == 1);
        pen = 1'b1;
        pe = e;
        e++;
      end
    end
    bit_en_i = 0;
  endtask

  initial begin
    // R1, R5: transparent path, stuffing disabled despite selects
    run_scn(0, 1'b0, 1'b1, 24'hFFFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
    // R2, R3: global stuffing with empty mask
    run_scn(0, 1'b1, 1'b1, 24'h000000, 1'b0, 1'b0, 1'b0, 1'b0);
    // R4: per-channel mask
    run_scn(0, 1'b1, 1'b0, 24'h5A3C81, 1'b0, 1'b0, 1'b0, 1'b0);
    // R6, R8: bit-2 yellow ahead of zero test
    run_scn(0, 1'b1, 1'b1, 24'h000000, 1'b1, 1'b0, 1'b0, 1'b0);
    // R7: S-bit yellow in last frame
    run_scn(1, 1'b1, 1'b0, 24'hFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0);
    // R9: blue overrides everything
    run_scn(0, 1'b1, 1'b1, 24'hFFFFFF, 1'b1, 1'b1, 1'b1, 1'b0);
    // R12: gaps in the bit enable
    run_scn(1, 1'b1, 1'b0, 24'h0F0F0F, 1'b0, 1'b0, 1'b0, 1'b1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule